// File: doc/BRIEF.md
# DMA Channel Address Generator

This block keeps the source and destination pointers of one DMA channel and puts them on a 20-bit address bus during a transfer. Each pointer is stored as a 4-bit upper register and a 16-bit lower register. Software loads and reads these registers through a 16-bit register port. The upper register keeps only its low four bits.

A transfer starts with a one-cycle start pulse while the block is idle. It then runs a read phase that drives the source pointer, followed by a write phase that drives the destination pointer. Each phase lasts one cycle. When the write phase ends, each pointer steps on its own. It moves up, moves down or holds, according to the direction code latched at start. The step is 2 for a word transfer and 1 for a byte transfer. The pointers come out of reset with unspecified values, so all four registers must be loaded before the first transfer.

Top module: `dma_addr_gen`

## Requirements
- R1: A pointer's 20-bit value is its upper register bits 3:0 as address bits 19:16, joined with its lower register as bits 15:0. Register select codes: 0 source lower, 1 source upper, 2 destination lower, 3 destination upper.
- R2: Bits 15:4 written to an upper register are discarded, and an upper register always reads back with bits 15:4 zero.
- R3: In the read phase (`bus_valid`=1, `bus_wr`=0), `bus_addr` equals the source pointer.
- R4: In the write phase (`bus_valid`=1, `bus_wr`=1), `bus_addr` equals the destination pointer.
- R5: A `xfer_start` seen while idle gives one read-phase cycle, then one write-phase cycle, then idle. A `xfer_start` seen while busy is ignored.
- R6: Each pointer follows its own direction code, latched at start: 0 or 3 hold, 1 increment, 2 decrement.
- R7: The step size is 2 when `xfer_word`=1 and 1 when `xfer_word`=0.
- R8: A step carries or borrows across bit 15 into bits 19:16 and wraps modulo 2^20.
- R9: The pointers update on the clock edge that ends the write phase, so the next transfer drives the updated addresses.
- R10: A register write to either half of a pointer, on the same edge as that pointer's update, wins. The written half takes the new data, the other half keeps its old value, and the step is dropped.
- R11: `reg_rdata` shows the live value of the selected register, registered one cycle after `reg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| xfer_start | input | 1 | Start pulse for one transfer |
| xfer_word | input | 1 | 1 = word step, 0 = byte step |
| src_dir | input | 2 | Source step direction |
| dst_dir | input | 2 | Destination step direction |
| bus_addr | output | 20 | Registered bus address |
| bus_valid | output | 1 | A transfer phase is active |
| bus_wr | output | 1 | 0 = read phase, 1 = write phase |

## Verification
A start pulse sampled on edge E0 makes the read-phase address visible just after E0. The write-phase address follows just after E1. The updated pointers and the drop of `bus_valid` follow just after E2.

Read data appears one edge after `reg_sel` is applied. The bench drives every input on the falling edge and samples on the next falling edge after the edge at which each result is due. No value is read in the same cycle its stimulus is applied.

For the write-priority case, the register write is placed on the falling edge inside the write phase, so that it lands on the same edge as the pointer update.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD  = 2'd0,
    DIR_UP    = 2'd1,
    DIR_DOWN  = 2'd2,
    DIR_HOLD2 = 2'd3
  } step_dir_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_t;
endpackage

// File: rtl/dma_addr_ptr.sv
module dma_addr_ptr
  import dma_addr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LO_W   = 16
) (
  input  logic              clk,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [LO_W-1:0]   wdata,
  input  logic              step_en,
  input  step_dir_t         dir,
  input  logic              word,
  output logic [ADDR_W-1:0] ptr_q
);
  localparam int HI_W = ADDR_W - LO_W;

  logic [HI_W-1:0]   hi_q;
  logic [LO_W-1:0]   lo_q;
  logic [ADDR_W-1:0] stride;
  logic [ADDR_W-1:0] nxt;

  assign ptr_q  = {hi_q, lo_q};
  assign stride = word ? ADDR_W'(2) : ADDR_W'(1);

  always_comb begin
    case (dir)
      DIR_UP:   nxt = ptr_q + stride;
      DIR_DOWN: nxt = ptr_q - stride;
      default:  nxt = ptr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_lo) lo_q <= wdata;
    if (wr_hi) hi_q <= wdata[HI_W-1:0];
    if (step_en && !wr_lo && !wr_hi) begin
      hi_q <= nxt[ADDR_W-1:LO_W];
      lo_q <= nxt[LO_W-1:0];
    end
  end
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_addr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      word_in,
  input  logic [1:0] sdir_in,
  input  logic [1:0] ddir_in,
  output phase_t    ph_nxt,
  output logic      upd,
  output logic      word_q,
  output step_dir_t sdir_q,
  output step_dir_t ddir_q
);
  phase_t ph_q;

  always_comb begin
    case (ph_q)
      PH_IDLE:  ph_nxt = start ? PH_READ : PH_IDLE;
      PH_READ:  ph_nxt = PH_WRITE;
      default:  ph_nxt = PH_IDLE;
    endcase
  end

  assign upd = (ph_q == PH_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      word_q <= 1'b0;
      sdir_q <= DIR_HOLD;
      ddir_q <= DIR_HOLD;
    end else begin
      ph_q <= ph_nxt;
      if (ph_q == PH_IDLE && start) begin
        word_q <= word_in;
        sdir_q <= step_dir_t'(sdir_in);
        ddir_q <= step_dir_t'(ddir_in);
      end
    end
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_addr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LO_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [LO_W-1:0]   reg_wdata,
  output logic [LO_W-1:0]   reg_rdata,
  input  logic              xfer_start,
  input  logic              xfer_word,
  input  logic [1:0]        src_dir,
  input  logic [1:0]        dst_dir,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_valid,
  output logic              bus_wr
);
  localparam int NPTR = 2;

  phase_t    ph_nxt;
  logic      upd;
  logic      word_q;
  step_dir_t sdir_q;
  step_dir_t ddir_q;
  logic [NPTR-1:0][ADDR_W-1:0] ptr_all;
  logic [ADDR_W-1:0] src_ptr;
  logic [ADDR_W-1:0] dst_ptr;
  logic [ADDR_W-1:0] sel_ptr;

  dma_addr_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (xfer_start),
    .word_in (xfer_word),
    .sdir_in (src_dir),
    .ddir_in (dst_dir),
    .ph_nxt  (ph_nxt),
    .upd     (upd),
    .word_q  (word_q),
    .sdir_q  (sdir_q),
    .ddir_q  (ddir_q)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dma_addr_ptr #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_ptr (
      .clk     (clk),
      .wr_lo   (reg_wr && reg_sel == 2'(2*g)),
      .wr_hi   (reg_wr && reg_sel == 2'(2*g+1)),
      .wdata   (reg_wdata),
      .step_en (upd),
      .dir     ((g == 0) ? sdir_q : ddir_q),
      .word    (word_q),
      .ptr_q   (ptr_all[g])
    );
  end

  assign src_ptr = ptr_all[0];
  assign dst_ptr = ptr_all[1];
  assign sel_ptr = ptr_all[reg_sel[1]];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid <= 1'b0;
      bus_wr    <= 1'b0;
      bus_addr  <= '0;
      reg_rdata <= '0;
    end else begin
      bus_valid <= (ph_nxt != PH_IDLE);
      bus_wr    <= (ph_nxt == PH_WRITE);
      if (ph_nxt != PH_IDLE)
        bus_addr <= (ph_nxt == PH_WRITE) ? dst_ptr : src_ptr;
      reg_rdata <= reg_sel[0] ? LO_W'(sel_ptr[ADDR_W-1:LO_W])
                              : sel_ptr[LO_W-1:0];
    end
  end
endmodule

// File: rtl/dma_addr_chk.sv
module dma_addr_chk
  import dma_addr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LO_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic [LO_W-1:0]   reg_wdata,
  input logic [LO_W-1:0]   reg_rdata,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_valid,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] src_ptr,
  input logic [ADDR_W-1:0] dst_ptr,
  input logic              upd,
  input logic              word_q,
  input step_dir_t         sdir_q
);
  localparam int HI_W = ADDR_W - LO_W;

  assert_rd_then_wr_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_wr) |=> (bus_valid && bus_wr));

  assert_wr_then_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_wr) |=> !bus_valid);

  assert_hi_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
    $past(reg_sel[0]) |-> (reg_rdata[LO_W-1:HI_W] == '0));

  assert_rd_src_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_wr) |-> (bus_addr == $past(src_ptr)));

  assert_wr_dst_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_wr) |-> (bus_addr == $past(dst_ptr)));

  assert_byte_up_R7: assert property (@(posedge clk) disable iff (rst)
    (upd && !(reg_wr && !reg_sel[1]) && sdir_q == DIR_UP && !word_q)
      |=> (src_ptr == $past(src_ptr) + ADDR_W'(1)));

  assert_src_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (upd && !(reg_wr && !reg_sel[1]) && (sdir_q == DIR_HOLD || sdir_q == DIR_HOLD2))
      |=> $stable(src_ptr));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == 2'd0) |=> (src_ptr[LO_W-1:0] == $past(reg_wdata)));
endmodule

bind dma_addr_gen dma_addr_chk #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .bus_addr  (bus_addr),
  .bus_valid (bus_valid),
  .bus_wr    (bus_wr),
  .src_ptr   (src_ptr),
  .dst_ptr   (dst_ptr),
  .upd       (upd),
  .word_q    (word_q),
  .sdir_q    (sdir_q)
);

// File: tb/dma_addr_gen_test.sv
module dma_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        xfer_start = 1'b0;
  logic        xfer_word = 1'b0;
  logic [1:0]  src_dir = 2'd0;
  logic [1:0]  dst_dir = 2'd0;
  logic [19:0] bus_addr;
  logic        bus_valid;
  logic        bus_wr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  dma_addr_gen uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_start(xfer_start),
    .xfer_word(xfer_word), .src_dir(src_dir), .dst_dir(dst_dir),
    .bus_addr(bus_addr), .bus_valid(bus_valid), .bus_wr(bus_wr)
  );

  typedef struct packed {
    logic [19:0] src;
    logic [19:0] dst;
    logic        word;
    logic [1:0]  sd;
    logic [1:0]  dd;
    logic [19:0] xs;
    logic [19:0] xd;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{20'h12340, 20'h56780, 1'b1, 2'd1, 2'd1, 20'h12342, 20'h56782},
    '{20'h0FFFF, 20'h10000, 1'b0, 2'd1, 2'd2, 20'h10000, 20'h0FFFF},
    '{20'hFFFFF, 20'h00000, 1'b0, 2'd1, 2'd2, 20'h00000, 20'hFFFFF},
    '{20'hFFFFE, 20'h00001, 1'b1, 2'd1, 2'd2, 20'h00000, 20'hFFFFF},
    '{20'hABCDE, 20'h13579, 1'b1, 2'd0, 2'd1, 20'hABCDE, 20'h1357B},
    '{20'h2FFFF, 20'h30001, 1'b1, 2'd2, 2'd3, 20'h2FFFD, 20'h30001},
    '{20'h00010, 20'h8000F, 1'b0, 2'd2, 2'd1, 20'h0000F, 20'h80010}
  };

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [15:0] data);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    data = reg_rdata;
  endtask

  task automatic load(input logic [19:0] s, input logic [19:0] d);
    wr_reg(2'd0, s[15:0]);
    wr_reg(2'd1, {12'hA5A, s[19:16]});
    wr_reg(2'd2, d[15:0]);
    wr_reg(2'd3, {12'h5A5, d[19:16]});
  endtask

  task automatic read_ptrs(output logic [19:0] s, output logic [19:0] d);
    logic [15:0] lo, hi;
    rd_reg(2'd0, lo); rd_reg(2'd1, hi); s = {hi[3:0], lo};
    rd_reg(2'd2, lo); rd_reg(2'd3, hi); d = {hi[3:0], lo};
  endtask

  // Start on E0; read phase visible after E0, write phase after E1, idle after E2.
  task automatic run_xfer(input logic w, input logic [1:0] sd, input logic [1:0] dd,
                          output logic [19:0] a_rd, output logic [19:0] a_wr);
    @(negedge clk);
    xfer_start = 1'b1; xfer_word = w; src_dir = sd; dst_dir = dd;
    @(negedge clk);
    xfer_start = 1'b0;
    a_rd = bus_addr;
    chk("R5 read phase flags", {18'd0, bus_valid, bus_wr}, 20'd2);
    @(negedge clk);
    a_wr = bus_addr;
    chk("R5 write phase flags", {18'd0, bus_valid, bus_wr}, 20'd3);
    @(negedge clk);
    chk("R5 idle after write", {19'd0, bus_valid}, 20'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [19:0] ar, aw, s, d;
    logic [15:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R5 reset idle", {18'd0, bus_valid, bus_wr}, 20'd0);

    for (int i = 0; i < NV; i++) begin
      load(VECS[i].src, VECS[i].dst);
      read_ptrs(s, d);
      chk("R1 src compose", s, VECS[i].src);
      chk("R1 dst compose", d, VECS[i].dst);
      run_xfer(VECS[i].word, VECS[i].sd, VECS[i].dd, ar, aw);
      chk("R3 read addr", ar, VECS[i].src);
      chk("R4 write addr", aw, VECS[i].dst);
      read_ptrs(s, d);
      chk("R6 R7 R8 R11 src next", s, VECS[i].xs);
      chk("R6 R7 R8 R11 dst next", d, VECS[i].xd);
      run_xfer(1'b0, 2'd0, 2'd0, ar, aw);
      chk("R9 next read addr", ar, VECS[i].xs);
      chk("R9 next write addr", aw, VECS[i].xd);
    end

    // R2: reserved upper bits discarded and read as zero
    wr_reg(2'd3, 16'hFFF5);
    rd_reg(2'd3, rv);
    chk("R2 upper readback", {4'd0, rv}, 20'h00005);

    // R10: lower-half write on the update edge wins; upper half keeps old value
    load(20'h4FFFE, 20'h00100);
    @(negedge clk);
    xfer_start = 1'b1; xfer_word = 1'b1; src_dir = 2'd1; dst_dir = 2'd1;
    @(negedge clk);
    xfer_word = 1'b0; dst_dir = 2'd2;   // R5: start seen while busy is ignored
    @(negedge clk);
    xfer_start = 1'b0;
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 16'h1111;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R5 busy start ignored", {19'd0, bus_valid}, 20'd0);
    @(negedge clk);
    chk("R5 still idle", {19'd0, bus_valid}, 20'd0);
    read_ptrs(s, d);
    chk("R10 written src", s, 20'h41111);
    chk("R10 dst still steps", d, 20'h00102);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule